// File: doc/BRIEF.md
# Long-Word Instruction Prefetch Buffer

This block feeds a 16-bit instruction decoder from an external memory port that is 32, 16 or 8 bits wide. Memory is only ever read as whole aligned 32-bit long words. Both halves of each long word are held locally, so the second word reaches the decoder without another trip to the bus. The decoder takes words over a valid/ready stream, and each word carries its byte address.

The decoder steers fetching with two inputs. A redirect gives a new word-aligned target and restarts the stream there. A flush empties the buffer and stops fetching until the next redirect. When the target is the odd word of a long word, the whole long word is still read, but only the odd word is handed on. On a narrow port the sequencer splits each long word into two or four beats at rising addresses and assembles them most significant first. A fetch that is cancelled while on the bus still runs to its last beat, and its data is thrown away.

Top module: `ifetch_lw_buf`

## Requirements
- R1: Every fetch reads one complete long word: it starts at a byte address with bits [1:0] equal to 0 and runs all of its beats. A new fetch never starts while another is in progress.
- R2: `mem_size` picks the port width and is sampled when a fetch starts. 2'b00 means 32 bits: one beat, data on `mem_rdata[31:0]`, even word in [31:16]. 2'b01 means 16 bits: two beats on `mem_rdata[15:0]`. 2'b10 or 2'b11 means 8 bits: four beats on `mem_rdata[7:0]`. Earlier beats are the more significant part of the long word.
- R3: While `word_valid` is high, `mem_req` is low. The second word of a long word is delivered with no bus beat acknowledged between the two deliveries.
- R4: After a redirect to address A, the decoder receives the words at A, A+2, A+4 and so on, in order, and each `word_data` equals the memory word at `word_addr`.
- R5: After a redirect to an odd-word target (bit 1 = 1), the first word delivered is the target itself. The even word of that long word is fetched but never presented, and the fetch base is the target with bits [1:0] cleared.
- R6: On a narrow port, beat k of a fetch uses byte address base + 2k on a 16-bit port and base + k on an 8-bit port, so the even word is read before the odd word.
- R7: While `mem_req` is high and `mem_ack` is low, `mem_req` stays high and `mem_addr` does not change in the next cycle.
- R8: In a cycle with `redirect` high, no word is transferred and all buffered words are dropped, so `word_valid` is low in the next cycle. A fetch that is in progress completes on the bus but its data is discarded. When `redirect` and `flush` are high together, the redirect takes effect.
- R9: After `flush`, with `redirect` low, `word_valid` is low from the next cycle on. Apart from a fetch already in progress, no fetch starts until the next redirect.
- R10: While `word_valid` is high and `word_ready` is low, with no redirect or flush, `word_valid`, `word_data` and `word_addr` hold their values into the next cycle.
- R11: After reset, `word_valid` and `mem_req` stay low until the first redirect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redirect | input | 1 | Restart fetching at `redirect_addr` |
| redirect_addr | input | AW-1 | Target byte address bits [AW-1:1]; bit 0 is implied zero |
| flush | input | 1 | Drop buffered words and stop fetching |
| word_valid | output | 1 | A word is offered to the decoder |
| word_ready | input | 1 | The decoder accepts the offered word |
| word_data | output | 16 | Offered instruction word |
| word_addr | output | AW | Byte address of the offered word |
| mem_req | output | 1 | Bus beat requested |
| mem_addr | output | AW | Byte address of the current beat |
| mem_size | input | 2 | Port width code (see R2) |
| mem_ack | input | 1 | Beat complete; `mem_rdata` is valid |
| mem_rdata | input | 32 | Read data for the beat |

## Verification
The internal state that can go wrong is small: the fetch pointer, the skip-even flag, the discard flag, the beat counter and the two word slots. A fault in any of them shows up quickly at the ports. A wrong pointer or skip flag gives a wrong `word_addr` on the next delivered word. A beat counter that slips moves `mem_addr` off its expected ascending step on the very next beat. A discard flag that fails to hold lets stale words appear in the cycle after a fetch that should have been dropped completes. A slot that is not cleared gives a visible `word_valid` in the cycle after a flush or redirect. The bench models the expected word stream and the bus beat sequence behaviourally and compares them against the ports every cycle, including the requirement that no beat is acknowledged between the even and odd deliveries of one long word.

// File: rtl/ifb_pkg.sv
// Shared constants and helpers for the long-word prefetch buffer.
// Assumes big-endian assembly: earlier beats form the more significant bits.
package ifb_pkg;

    localparam int HW_W = 16;   // decoder word width
    localparam int LW_W = 32;   // fetch unit width

    typedef enum logic [1:0] {
        PW_32  = 2'b00,
        PW_16  = 2'b01,
        PW_8   = 2'b10,
        PW_8X  = 2'b11
    } port_width_e;

    // Index of the last beat of a long word for a given port width.
    function automatic logic [1:0] final_beat(input logic [1:0] sz);
        case (port_width_e'(sz))
            PW_32:   return 2'd0;
            PW_16:   return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    // Byte offset of a beat inside its long word.
    function automatic logic [1:0] beat_offset(input logic [1:0] sz, input logic [1:0] beat);
        case (port_width_e'(sz))
            PW_32:   return 2'b00;
            PW_16:   return {beat[0], 1'b0};
            default: return beat;
        endcase
    endfunction

    // Append one beat's lanes below the bits gathered so far.
    function automatic logic [LW_W-1:0] merge_beat(input logic [1:0] sz,
                                                   input logic [LW_W-1:0] acc,
                                                   input logic [LW_W-1:0] rdata);
        case (port_width_e'(sz))
            PW_32:   return rdata;
            PW_16:   return {acc[15:0], rdata[15:0]};
            default: return {acc[23:0], rdata[7:0]};
        endcase
    endfunction

endpackage

// File: rtl/ifb_bus_seq.sv
// Bus sequencer: runs one aligned long-word read as 1, 2 or 4 beats and
// assembles the result. Assumes start is only raised while idle.
// A cancel during a fetch lets the beats finish but suppresses the result.
module ifb_bus_seq
    import ifb_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-3:0]   start_lw,
    input  logic [1:0]      start_size,
    input  logic            cancel,
    input  logic            mem_ack,
    input  logic [LW_W-1:0] mem_rdata,
    output logic            busy,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    output logic            lw_valid,
    output logic [LW_W-1:0] lw_data,
    output logic [AW-3:0]   lw_addr
);

    localparam int LWA = AW - 2;

    logic            busy_q;
    logic            drop_q;
    logic [LWA-1:0]  base_q;
    logic [1:0]      size_q;
    logic [1:0]      beat_q;
    logic [LW_W-1:0] acc_q;
    logic            last_beat;
    logic            done;

    // Beat bookkeeping shared by the outputs and the state update.
    always_comb begin
        last_beat = (beat_q == final_beat(size_q));
        done      = busy_q && mem_ack && last_beat;
    end

    // Fetch state: latch base and width on start, step beats on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            base_q <= '0;
            size_q <= 2'b00;
            beat_q <= 2'd0;
            acc_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            base_q <= start_lw;
            size_q <= start_size;
            beat_q <= 2'd0;
        end else if (busy_q && mem_ack) begin
            if (last_beat) begin
                busy_q <= 1'b0;
            end else begin
                beat_q <= beat_q + 2'd1;
                acc_q  <= merge_beat(size_q, acc_q, mem_rdata);
            end
        end
    end

    // Discard marker: a cancel during a fetch spoils its result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q <= 1'b0;
        end else if (done) begin
            drop_q <= 1'b0;
        end else if (busy_q && cancel) begin
            drop_q <= 1'b1;
        end
    end

    // Bus side and result outputs.
    always_comb begin
        busy     = busy_q;
        mem_req  = busy_q;
        mem_addr = {base_q, beat_offset(size_q, beat_q)};
        lw_valid = done && !drop_q && !cancel;
        lw_data  = merge_beat(size_q, acc_q, mem_rdata);
        lw_addr  = base_q;
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R7
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q); // R1

endmodule

// File: rtl/ifb_word_buf.sv
// Two-slot word buffer holding the even and odd halves of one long word.
// Presents the even slot first when it is live, then the odd slot.
// Assumes load only arrives while both slots are empty.
module ifb_word_buf
    import ifb_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cancel,
    input  logic            load,
    input  logic [LW_W-1:0] load_data,
    input  logic [AW-3:0]   load_lw,
    input  logic            load_skip_even,
    input  logic            take,
    output logic            empty,
    output logic            word_valid,
    output logic [HW_W-1:0] word_data,
    output logic [AW-1:0]   word_addr
);

    logic [HW_W-1:0] even_q;
    logic [HW_W-1:0] odd_q;
    logic            even_v;
    logic            odd_v;
    logic [AW-3:0]   lw_q;

    // Slot update: cancel clears, load fills, take retires the oldest slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            even_q <= '0;
            odd_q  <= '0;
            even_v <= 1'b0;
            odd_v  <= 1'b0;
            lw_q   <= '0;
        end else if (cancel) begin
            even_v <= 1'b0;
            odd_v  <= 1'b0;
        end else if (load) begin
            even_q <= load_data[LW_W-1:HW_W];
            odd_q  <= load_data[HW_W-1:0];
            even_v <= !load_skip_even;
            odd_v  <= 1'b1;
            lw_q   <= load_lw;
        end else if (take) begin
            if (even_v) begin
                even_v <= 1'b0;
            end else begin
                odd_v <= 1'b0;
            end
        end
    end

    // Offer the oldest live slot with its byte address.
    always_comb begin
        empty      = !even_v && !odd_v;
        word_valid = even_v || odd_v;
        word_data  = even_v ? even_q : odd_q;
        word_addr  = {lw_q, !even_v, 1'b0};
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && !take && !cancel |=> word_valid && $stable(word_data) && $stable(word_addr)); // R10
    AST_LOAD_INTO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> empty); // R3

endmodule

// File: rtl/ifetch_lw_buf.sv
// Long-word instruction prefetch buffer top. Keeps the fetch pointer and
// the run state, starts a long-word fetch whenever the buffer has drained,
// and routes results into the word buffer.
// Assumes redirect targets are word aligned (bit 0 implied zero).
module ifetch_lw_buf
    import ifb_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect,
    input  logic [AW-1:1]   redirect_addr,
    input  logic            flush,
    output logic            word_valid,
    input  logic            word_ready,
    output logic [HW_W-1:0] word_data,
    output logic [AW-1:0]   word_addr,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic [1:0]      mem_size,
    input  logic            mem_ack,
    input  logic [LW_W-1:0] mem_rdata
);

    localparam int LWA = AW - 2;

    logic            running_q;
    logic [LWA-1:0]  ptr_q;
    logic            skip_q;
    logic            cancel;
    logic            seq_start;
    logic            seq_busy;
    logic            lw_valid;
    logic [LW_W-1:0] lw_data;
    logic [LWA-1:0]  lw_addr;
    logic            buf_empty;
    logic            take;

    // Control decisions for this cycle.
    always_comb begin
        cancel    = redirect || flush;
        seq_start = running_q && !seq_busy && buf_empty && !cancel;
        take      = word_valid && word_ready && !cancel;
    end

    // Fetch pointer and run state: redirect reloads, flush halts, results advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            ptr_q     <= '0;
            skip_q    <= 1'b0;
        end else if (redirect) begin
            running_q <= 1'b1;
            ptr_q     <= redirect_addr[AW-1:2];
            skip_q    <= redirect_addr[1];
        end else if (flush) begin
            running_q <= 1'b0;
        end else if (lw_valid) begin
            ptr_q  <= ptr_q + 1'b1;
            skip_q <= 1'b0;
        end
    end

    ifb_bus_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (seq_start),
        .start_lw   (ptr_q),
        .start_size (mem_size),
        .cancel     (cancel),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .busy       (seq_busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .lw_valid   (lw_valid),
        .lw_data    (lw_data),
        .lw_addr    (lw_addr)
    );

    ifb_word_buf #(.AW(AW)) u_buf (
        .clk            (clk),
        .rst_n          (rst_n),
        .cancel         (cancel),
        .load           (lw_valid),
        .load_data      (lw_data),
        .load_lw        (lw_addr),
        .load_skip_even (skip_q),
        .take           (take),
        .empty          (buf_empty),
        .word_valid     (word_valid),
        .word_data      (word_data),
        .word_addr      (word_addr)
    );

    AST_BUFFERED_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !mem_req); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !word_valid); // R9
    AST_REDIRECT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !word_valid); // R8

endmodule

// File: tb/ifetch_lw_buf_tb.sv
// Bench: behavioural memory slave plus a reference model of the word stream
// and beat sequence, compared against the ports on every falling edge.
module ifetch_lw_buf_tb;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          redirect = 1'b0;
    logic [AW-1:1] redirect_addr = '0;
    logic          flush = 1'b0;
    logic          word_valid;
    logic          word_ready = 1'b0;
    logic [15:0]   word_data;
    logic [AW-1:0] word_addr;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size = 2'b00;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '1;

    always #10 clk = ~clk;

    ifetch_lw_buf #(.AW(AW)) u_dut (
        .clk (clk), .rst_n (rst_n), .redirect (redirect), .redirect_addr (redirect_addr),
        .flush (flush), .word_valid (word_valid), .word_ready (word_ready),
        .word_data (word_data), .word_addr (word_addr), .mem_req (mem_req),
        .mem_addr (mem_addr), .mem_size (mem_size), .mem_ack (mem_ack), .mem_rdata (mem_rdata)
    );

    int n_chk = 0;
    int n_err = 0;
    int n_words = 0;
    int cyc = 0;

    // Stimulus controls set by the sequence, consumed on the falling edge.
    bit  redir_pend = 0;
    int  redir_tgt = 0;
    bit  flush_pend = 0;
    int  ready_mode = 0;
    int  ack_mode = 0;
    logic [1:0] size_want = 2'b00;

    // Reference model state.
    int  exp_addr = 0;
    bit  halted = 1;
    bit  armed = 0;
    bit  m_inflight = 0;
    int  m_beat = 0;
    int  m_base = 0;
    int  m_size = 0;
    int  last_base = -1;
    int  acks = 0;
    bit  pend_odd_v = 0;
    int  pend_odd = 0;
    int  acks_at = 0;
    bit  hold_prev = 0;
    logic [15:0]   prev_data = '0;
    logic [AW-1:0] prev_addr = '0;
    bit  chk_empty_next = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [7:0] mb(input int a);
        int v;
        v = a * 37 + (a >>> 8) * 11 + 7;
        return v[7:0];
    endfunction

    function automatic logic [15:0] mw(input int a);
        return {mb(a), mb(a + 1)};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle model, slave and stimulus, evaluated away from the active edge.
    always @(negedge clk) begin
        int  nb;
        int  bpb;
        bit  ack;
        bit  rdy;
        bit  xfer;
        cyc++;
        if (rst_n) begin
            // R10: a held word must persist.
            if (hold_prev) begin
                chk(word_valid && word_data == prev_data && word_addr == prev_addr,
                    "R10 hold", int'(word_addr), int'(prev_addr));
            end
            // R8: after a redirect the buffer is empty.
            if (chk_empty_next) chk(!word_valid, "R8 redirect drops words", int'(word_valid), 0);
            chk_empty_next = 0;
            // R9: halted by flush, nothing is offered.
            if (armed) chk(!word_valid, "R9 flush empties", int'(word_valid), 0);
            // R3: buffered words never overlap a bus request.
            if (word_valid) chk(!mem_req, "R3 no bus while buffered", int'(mem_req), 0);

            // Memory slave and beat model (R1, R2, R6, R7).
            ack = 1'b0;
            if (mem_req) begin
                if (!m_inflight) begin
                    m_inflight = 1;
                    m_beat = 0;
                    m_base = int'(mem_addr);
                    m_size = int'(mem_size);
                    chk(mem_addr[1:0] == 2'b00, "R1 fetch aligned", int'(mem_addr), m_base & ~3);
                    if (armed) chk(0, "R9 fetch after flush", int'(mem_addr), -1);
                end
                bpb = (m_size == 0) ? 4 : (m_size == 1) ? 2 : 1;
                nb  = 4 / bpb;
                chk(int'(mem_addr) == m_base + m_beat * bpb, "R6 beat address",
                    int'(mem_addr), m_base + m_beat * bpb);
                ack = (ack_mode == 0) ? 1'b1 : (lfsr[1:0] != 2'b00);
                if (ack) begin
                    if (m_size == 0)      mem_rdata = {mw(int'(mem_addr)), mw(int'(mem_addr) + 2)};
                    else if (m_size == 1) mem_rdata = {16'hC3C3, mw(int'(mem_addr))};
                    else                  mem_rdata = {24'h5A5A5A, mb(int'(mem_addr))};
                    m_beat++;
                    acks++;
                    if (m_beat == nb) begin
                        m_inflight = 0;
                        last_base = m_base;
                    end
                end else begin
                    mem_rdata = '1;
                end
            end else begin
                chk(!m_inflight, "R7 request held until ack", int'(mem_req), 1);
                m_inflight = 0;
                mem_rdata = '1;
                mem_size = size_want;
            end
            mem_ack = ack;

            // Decoder side stimulus.
            rdy = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[3] : cyc[0];
            word_ready = rdy;
            redirect = redir_pend;
            flush = flush_pend;
            if (redir_pend) redirect_addr = AW'(redir_tgt) >> 1;
            redir_pend = 0;
            flush_pend = 0;

            // Word transfer at the coming edge (R4, R5, R3).
            xfer = word_valid && rdy && !redirect && !flush;
            if (xfer) begin
                chk(int'(word_addr) == exp_addr, "R4 word order", int'(word_addr), exp_addr);
                chk(word_data == mw(int'(word_addr)), "R4 word data", int'(word_data), int'(mw(int'(word_addr))));
                chk((int'(word_addr) & ~3) == last_base, "R5 word from fetched long word",
                    int'(word_addr) & ~3, last_base);
                if (word_addr[1] == 1'b0) begin
                    pend_odd_v = 1;
                    pend_odd = int'(word_addr) + 2;
                    acks_at = acks;
                end else if (pend_odd_v && int'(word_addr) == pend_odd) begin
                    chk(acks == acks_at, "R3 second word without bus", acks - acks_at, 0);
                    pend_odd_v = 0;
                end
                exp_addr += 2;
                n_words++;
            end

            if (redirect) begin
                exp_addr = redir_tgt;
                halted = 0;
                pend_odd_v = 0;
                chk_empty_next = 1;
            end else if (flush) begin
                halted = 1;
                pend_odd_v = 0;
            end
            armed = halted;
            hold_prev = word_valid && !rdy && !redirect && !flush;
            prev_data = word_data;
            prev_addr = word_addr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic go(input int tgt);
        redir_tgt = tgt;
        redir_pend = 1;
        while (redir_pend) step();
    endtask

    task automatic wait_words(input int n);
        int base;
        base = n_words;
        while (n_words < base + n) step();
    endtask

    task automatic wait_midfetch();
        step();
        while (!(m_inflight && m_beat >= 1)) step();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        // R11: idle after reset until the first redirect.
        repeat (5) begin
            step();
            chk(!word_valid, "R11 reset valid low", int'(word_valid), 0);
            chk(!mem_req, "R11 reset no request", int'(mem_req), 0);
        end
        // R2 32-bit port, aligned target, zero-wait bus.
        size_want = 2'b00; ready_mode = 0; ack_mode = 0;
        go(32'h100);  wait_words(16);
        // R5 odd target with throttled decoder and slow bus.
        ready_mode = 1; ack_mode = 1;
        go(32'h206);  wait_words(16);
        // R2 R6 16-bit port, odd target.
        size_want = 2'b01;
        go(32'h40A);  wait_words(16);
        // R2 R6 8-bit port, alternating ready.
        size_want = 2'b10; ready_mode = 2;
        go(32'h1000); wait_words(16);
        size_want = 2'b11;
        go(32'h2002); wait_words(8);
        // R8 redirect while a fetch is on the bus.
        size_want = 2'b10; ready_mode = 1;
        wait_midfetch();
        go(32'h3006); wait_words(8);
        // R9 flush while a fetch is on the bus, then stay halted.
        wait_midfetch();
        flush_pend = 1;
        while (flush_pend) step();
        repeat (30) step();
        size_want = 2'b00;
        go(32'h50C);  wait_words(8);
        // R9 flush with words buffered.
        ready_mode = 2;
        while (!word_valid) step();
        flush_pend = 1;
        while (flush_pend) step();
        repeat (10) step();
        go(32'h600);  wait_words(6);
        // R8 redirect and flush together: redirect wins.
        size_want = 2'b01;
        flush_pend = 1;
        go(32'h7F2);  wait_words(6);
        repeat (5) step();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule